// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the protocol core of a small byte-wide serial EEPROM on a two-wire bus. It works on SCL and SDA samples that have already been synchronised into the system clock domain. From these it recognises bus framing, decides whether the bus is addressing this device, tracks a word pointer, and drives an active-low pull-down enable for the open-drain SDA pad.

Write data does not go straight into the array. Every accepted data byte is handed to a page-write commit unit together with its word address. The block then tells that unit either to commit the gathered page or to discard it. While the commit unit reports that a write cycle is running, the block ignores the bus completely. A host can therefore poll for completion by sending the device address until it is acknowledged. Reads fetch bytes from a memory port whose data must follow the address within one system clock. The array depth must be a power of two and at most 256 words. The page size must be a power of two smaller than the depth.

Top module: `twi_ee_target`

## Requirements
- R1: After reset `sda_oe_n_o` is 1 (bus released) and no page strobe is pulsed. A START is SDA falling while SCL stays high, and it aborts any command in progress, including one cut off mid-byte.
- R2: The first byte after START is compared MSB first. Bits 7..4 must equal the device code 1010, bits 3..1 must equal `strap_i`, and bit 0 selects read (1) or write (0). The byte is acknowledged (SDA pulled low in the 9th clock) only on a full match. On a mismatch the rest of the frame is ignored.
- R3: In a write frame, the next byte is the word address. It is acknowledged and loaded into the pointer. Address bits at or above log2(DEPTH) are ignored.
- R4: Each acknowledged data byte is passed to the commit unit at the current pointer. Only the low log2(PAGE) pointer bits then increment, wrapping inside the page. A STOP right after a data acknowledge commits the gathered bytes.
- R5: A STOP that arrives after the second bit of a following data byte has been clocked commits nothing and discards the gathered bytes.
- R6: A write frame that ends after the word address with a repeated START only sets the pointer. A read frame that follows returns the byte at that address.
- R7: Read bytes go out MSB first. The pointer increments after the 8th bit and wraps from DEPTH-1 to 0. A read frame without a word address starts at the current pointer.
- R8: A host acknowledge (SDA low in the 9th clock) continues a read with the next byte. A host NACK ends it, and SDA stays released until the next START.
- R9: While `busy_i` is high, the device address byte is not acknowledged.
- R10: While `wp_i` is high, the device and word address bytes are still acknowledged. Data bytes get a NACK, and nothing is loaded or committed.
- R11: `sda_oe_n_o` changes exactly HOLD_CLKS system clocks after SCL is seen falling, and never while SCL is high except when it is released on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired bus level) |
| strap_i | input | STRAP_W | Device address straps |
| wp_i | input | 1 | Write protect, high blocks data writes |
| busy_i | input | 1 | Write cycle in progress in the commit unit |
| sda_oe_n_o | output | 1 | SDA pull-down enable, 0 pulls the line low |
| mem_addr_o | output | log2(DEPTH) | Read address (word pointer) |
| mem_rdata_i | input | 8 | Read data at `mem_addr_o` |
| pg_load_o | output | 1 | Pulse: store one data byte in the page buffer |
| pg_addr_o | output | log2(DEPTH) | Word address of the loaded byte |
| pg_data_o | output | 8 | Loaded data byte |
| pg_commit_o | output | 1 | Pulse: start the write cycle for the gathered bytes |
| pg_drop_o | output | 1 | Pulse: discard the gathered bytes |

## Verification
The bench builds the block with DEPTH=128, PAGE=16, HOLD_CLKS=4 and a strap value of 101. A depth of 128 makes the ignored top address bit observable with a single byte write. It also brings the read wrap from 127 to 0 within three bytes. A page write that starts three bytes before the end of a 16-byte page shows the in-page rollover. A hold of four clocks against a 20-clock SCL half period lets the bench measure the drive delay exactly on every SDA change.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_DEV,    // receiving device address byte
    ST_WADDR,  // receiving word address
    ST_WDATA,  // receiving write data
    ST_SACK,   // target acknowledge slot
    ST_TX,     // shifting out read data
    ST_HACK    // host acknowledge slot
  } ee_state_t;
endpackage

// File: rtl/twi_bus_edges.sv
module twi_bus_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = ~scl_q & scl_i;
  assign scl_fall  = scl_q & ~scl_i;
  assign bus_start = scl_q & scl_i & sda_q & ~sda_i;
  assign bus_stop  = scl_q & scl_i & ~sda_q & sda_i;
endmodule

// File: rtl/twi_sda_hold.sv
module twi_sda_hold #(
  parameter int HOLD_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic val_i,
  input  logic rel_i,
  output logic oe_n_o
);
  localparam int CNT_W = $clog2(HOLD_CLKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      val_q  <= 1'b1;
      oe_n_o <= 1'b1;
    end else if (rel_i) begin
      pend_q <= 1'b0;
      oe_n_o <= 1'b1;
    end else if (set_i) begin
      cnt_q  <= CNT_W'(HOLD_CLKS);
      pend_q <= 1'b1;
      val_q  <= val_i;
    end else if (pend_q) begin
      if (cnt_q == CNT_W'(1)) begin
        oe_n_o <= val_q;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_word_ptr.sv
module twi_word_ptr #(
  parameter int ADDR_W = 8,
  parameter int PG_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              page_inc_i,
  input  logic              seq_inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_o;
    if (load_i)
      ptr_d = load_val_i;
    else if (page_inc_i)
      ptr_d = {ptr_o[ADDR_W-1:PG_W], ptr_o[PG_W-1:0] + 1'b1};
    else if (seq_inc_i)
      ptr_d = ptr_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_o <= '0;
    else        ptr_o <= ptr_d;
  end
endmodule

// File: rtl/twi_ee_target.sv
module twi_ee_target
  import twi_ee_pkg::*;
#(
  parameter int STRAP_W   = 3,
  parameter int DEPTH     = 256,
  parameter int PAGE      = 16,
  parameter int HOLD_CLKS = 4,
  parameter int DEV_CODE  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [STRAP_W-1:0]         strap_i,
  input  logic                       wp_i,
  input  logic                       busy_i,
  output logic                       sda_oe_n_o,
  output logic [$clog2(DEPTH)-1:0]   mem_addr_o,
  input  logic [7:0]                 mem_rdata_i,
  output logic                       pg_load_o,
  output logic [$clog2(DEPTH)-1:0]   pg_addr_o,
  output logic [7:0]                 pg_data_o,
  output logic                       pg_commit_o,
  output logic                       pg_drop_o
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PG_W   = $clog2(PAGE);
  localparam int CODE_W = 7 - STRAP_W;

  logic scl_rise, scl_fall, bus_start, bus_stop;
  ee_state_t   state_q, state_d, after_q, after_d;
  logic [2:0]  bit_q, bit_d;
  logic [6:0]  rx_q, rx_d;
  logic [7:0]  tx_q, tx_d, rx_byte;
  logic        ack_q, ack_d, ph_q, ph_d, hack_q, hack_d, data_q, data_d;
  logic        drv_set, drv_val, drv_rel;
  logic        ptr_load, ptr_pinc, ptr_sinc;
  logic        ld_d, cm_d, dr_d, dev_hit;
  logic [ADDR_W-1:0] ptr;

  twi_bus_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  twi_sda_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .set_i(drv_set), .val_i(drv_val),
    .rel_i(drv_rel), .oe_n_o(sda_oe_n_o)
  );

  twi_word_ptr #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(ptr_load),
    .load_val_i(rx_byte[ADDR_W-1:0]), .page_inc_i(ptr_pinc),
    .seq_inc_i(ptr_sinc), .ptr_o(ptr)
  );

  assign mem_addr_o = ptr;
  assign rx_byte    = {rx_q, sda_i};
  assign dev_hit    = (rx_byte[7:STRAP_W+1] == CODE_W'(DEV_CODE)) &&
                      (rx_byte[STRAP_W:1] == strap_i) && !busy_i;

  always_comb begin
    state_d = state_q;  after_d = after_q;  bit_d = bit_q;
    rx_d = rx_q;  tx_d = tx_q;  ack_d = ack_q;  ph_d = ph_q;
    hack_d = hack_q;  data_d = data_q;
    drv_set = 1'b0;  drv_val = 1'b1;  drv_rel = 1'b0;
    ptr_load = 1'b0;  ptr_pinc = 1'b0;  ptr_sinc = 1'b0;
    ld_d = 1'b0;  cm_d = 1'b0;  dr_d = 1'b0;
    if (bus_start) begin
      state_d = ST_DEV;  bit_d = '0;  drv_rel = 1'b1;
      dr_d = data_q;  data_d = 1'b0;
    end else if (bus_stop) begin
      state_d = ST_IDLE;  drv_rel = 1'b1;  data_d = 1'b0;
      if (data_q) begin
        if (state_q == ST_WDATA && bit_q <= 3'd1) cm_d = 1'b1;
        else                                      dr_d = 1'b1;
      end
    end else begin
      case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: if (scl_rise) begin
          rx_d  = rx_byte[6:0];
          bit_d = bit_q + 1'b1;
          if (bit_q == 3'd7) begin
            ph_d = 1'b0;  ack_d = 1'b1;  state_d = ST_SACK;
            if (state_q == ST_DEV) begin
              if (dev_hit) after_d = rx_byte[0] ? ST_TX : ST_WADDR;
              else         state_d = ST_IDLE;
            end else if (state_q == ST_WADDR) begin
              ptr_load = 1'b1;  after_d = ST_WDATA;
            end else if (wp_i) begin
              ack_d = 1'b0;  after_d = ST_IDLE;
            end else begin
              ld_d = 1'b1;  ptr_pinc = 1'b1;  data_d = 1'b1;  after_d = ST_WDATA;
            end
          end
        end
        ST_SACK: begin
          if (scl_rise) ph_d = 1'b1;
          if (scl_fall) begin
            drv_set = 1'b1;
            if (!ph_q) drv_val = ~ack_q;
            else begin
              state_d = after_q;  bit_d = '0;
              if (after_q == ST_TX) begin
                tx_d = {mem_rdata_i[6:0], 1'b0};  drv_val = mem_rdata_i[7];
              end
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            drv_set = 1'b1;  drv_val = tx_q[7];  tx_d = {tx_q[6:0], 1'b0};
          end
          if (scl_rise) begin
            bit_d = bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              ptr_sinc = 1'b1;  ph_d = 1'b0;  state_d = ST_HACK;
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            ph_d = 1'b1;  hack_d = ~sda_i;
          end
          if (scl_fall) begin
            drv_set = 1'b1;
            if (ph_q) begin
              if (hack_q) begin
                state_d = ST_TX;  bit_d = '0;
                tx_d = {mem_rdata_i[6:0], 1'b0};  drv_val = mem_rdata_i[7];
              end else begin
                state_d = ST_IDLE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  after_q <= ST_IDLE;  bit_q <= '0;
      rx_q <= '0;  tx_q <= '0;  ack_q <= 1'b0;  ph_q <= 1'b0;
      hack_q <= 1'b0;  data_q <= 1'b0;
      pg_load_o <= 1'b0;  pg_commit_o <= 1'b0;  pg_drop_o <= 1'b0;
      pg_addr_o <= '0;  pg_data_o <= '0;
    end else begin
      state_q <= state_d;  after_q <= after_d;  bit_q <= bit_d;
      rx_q <= rx_d;  tx_q <= tx_d;  ack_q <= ack_d;  ph_q <= ph_d;
      hack_q <= hack_d;  data_q <= data_d;
      pg_load_o <= ld_d;  pg_commit_o <= cm_d;  pg_drop_o <= dr_d;
      if (ld_d) begin
        pg_addr_o <= ptr;
        pg_data_o <= rx_byte;
      end
    end
  end
endmodule

// File: rtl/twi_ee_target_chk.sv
module twi_ee_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_n_o,
  input logic bus_start,
  input logic bus_stop,
  input logic wp_i,
  input logic busy_i,
  input logic pg_load_o,
  input logic pg_commit_o,
  input logic pg_drop_o
);
  // R11: SDA drive moves only with SCL low, or on release at START/STOP
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_n_o != $past(sda_oe_n_o)) |-> (!scl_i || $past(bus_start || bus_stop)));

  // R8: bus is released after any STOP
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> sda_oe_n_o);

  // R10: no byte reaches the page buffer under write protect
  p_wp_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pg_load_o |-> !wp_i);

  // R9: a commit can only come from a frame accepted while idle
  p_commit_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_commit_o |-> !busy_i);

  // R4: page strobes never coincide
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pg_load_o, pg_commit_o, pg_drop_o}));
endmodule

bind twi_ee_target twi_ee_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_n_o(sda_oe_n_o),
  .bus_start(bus_start), .bus_stop(bus_stop), .wp_i(wp_i), .busy_i(busy_i),
  .pg_load_o(pg_load_o), .pg_commit_o(pg_commit_o), .pg_drop_o(pg_drop_o)
);

// File: tb/twi_ee_target_tb.sv
module twi_ee_target_tb;
  localparam int H = 20;
  localparam int HOLD = 4;
  localparam logic [7:0] DW = 8'hAA;  // 1010 101 0
  localparam logic [7:0] DR = 8'hAB;  // 1010 101 1

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1, wp = 1'b0;
  logic dut_oe_n, pg_load, pg_commit, pg_drop;
  logic [6:0] mem_addr, pg_addr;
  logic [7:0] pg_data, mem_rdata;
  logic [7:0] mem [128];
  logic [7:0] pb_dat [16];
  logic [15:0] pb_val;
  logic [2:0] pb_hi;
  int busy_cnt;
  logic busy;
  wire sda_bus = host_sda & dut_oe_n;

  int total = 0, bad = 0, done = 0;
  int low_cnt, viol, delay_seen;
  logic oe_prev;
  logic [7:0] exp_m [128];
  logic [7:0] rbuf [8];
  logic [7:0] wbuf [8];
  logic all_ack;

  always #2 clk = ~clk;

  twi_ee_target #(.STRAP_W(3), .DEPTH(128), .PAGE(16), .HOLD_CLKS(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
    .strap_i(3'b101), .wp_i(wp), .busy_i(busy), .sda_oe_n_o(dut_oe_n),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .pg_load_o(pg_load),
    .pg_addr_o(pg_addr), .pg_data_o(pg_data), .pg_commit_o(pg_commit),
    .pg_drop_o(pg_drop)
  );

  assign mem_rdata = mem[mem_addr];
  assign busy = (busy_cnt != 0);

  // memory array and page-write commit model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i) ^ 8'hA5;
      pb_val <= '0;  pb_hi <= '0;  busy_cnt <= 0;
      for (int i = 0; i < 16; i++) pb_dat[i] <= '0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (pg_load) begin
        pb_val[pg_addr[3:0]] <= 1'b1;
        pb_dat[pg_addr[3:0]] <= pg_data;
        pb_hi <= pg_addr[6:4];
      end
      if (pg_commit) begin
        for (int i = 0; i < 16; i++)
          if (pb_val[i]) mem[{pb_hi, 4'(i)}] <= pb_dat[i];
        pb_val <= '0;
        busy_cnt <= 2000;
      end
      if (pg_drop) pb_val <= '0;
    end
  end

  // R11 monitor: every SDA drive change is HOLD+1 posedges into SCL low
  always @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= 0;  viol <= 0;  delay_seen <= 0;  oe_prev <= 1'b1;
    end else begin
      low_cnt <= host_scl ? 0 : low_cnt + 1;
      oe_prev <= dut_oe_n;
      if (dut_oe_n != oe_prev) begin
        delay_seen <= delay_seen + 1;
        if (host_scl || low_cnt != HOLD + 1) viol <= viol + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1;  wt(H);  host_scl = 1'b1;  wt(H);
    host_sda = 1'b0;  wt(H);  host_scl = 1'b0;  wt(2);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0;  wt(H);  host_scl = 1'b1;  wt(H);
    host_sda = 1'b1;  wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      host_sda = b[7-i];  wt(H);  host_scl = 1'b1;  wt(H);
      host_scl = 1'b0;  wt(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    host_sda = 1'b1;  wt(H);  host_scl = 1'b1;  wt(H/2);
    ack = (sda_bus == 1'b0);
    wt(H/2);  host_scl = 1'b0;  wt(2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic host_ack);
    host_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(H);  host_scl = 1'b1;  wt(H/2);
      b = {b[6:0], sda_bus};
      wt(H/2);  host_scl = 1'b0;  wt(2);
    end
    host_sda = ~host_ack;  wt(H);  host_scl = 1'b1;  wt(H);
    host_scl = 1'b0;  wt(2);  host_sda = 1'b1;
  endtask

  // read n bytes, optionally after a dummy write that sets the pointer
  task automatic rd_seq(input logic [7:0] a, input int n, input logic set_ptr);
    logic ack;
    all_ack = 1'b1;
    bus_start();
    if (set_ptr) begin
      send_byte(DW, ack);  all_ack &= ack;
      send_byte(a, ack);   all_ack &= ack;
      bus_start();
    end
    send_byte(DR, ack);  all_ack &= ack;
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    bus_stop();
  endtask

  task automatic wr_seq(input logic [7:0] a, input int n);
    logic ack;
    all_ack = 1'b1;
    bus_start();
    send_byte(DW, ack);  all_ack &= ack;
    send_byte(a, ack);   all_ack &= ack;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);  all_ack &= ack;
    end
    bus_stop();
  endtask

  task automatic poll(output int tries);
    logic ack;
    tries = 0;
    ack = 1'b0;
    while (!ack && tries < 40) begin
      tries++;
      bus_start();  send_byte(DW, ack);  bus_stop();
    end
  endtask

  task automatic t_reset();
    chk(dut_oe_n === 1'b1, "R1 reset release", dut_oe_n, 1);
    chk(!pg_load && !pg_commit && !pg_drop, "R1 reset strobes",
        {pg_load, pg_commit, pg_drop}, 0);
  endtask

  task automatic t_addr_match();
    logic ack;
    bus_start();  send_byte(8'hA4, ack);  bus_stop();
    chk(!ack, "R2 wrong strap nack", ack, 0);
    bus_start();  send_byte(8'hBA, ack);  bus_stop();
    chk(!ack, "R2 wrong code nack", ack, 0);
    bus_start();  send_byte(DW, ack);  bus_stop();
    chk(ack, "R2 match ack", ack, 1);
  endtask

  task automatic t_byte_write();
    int tries;
    wbuf[0] = 8'h3C;
    wr_seq(8'h85, 1);                 // R3: top bit dropped, lands at 0x05
    exp_m[5] = 8'h3C;
    chk(all_ack, "R4 byte write acks", all_ack, 1);
    poll(tries);
    chk(tries > 1, "R9 busy nack on first poll", tries, 2);
    chk(tries < 40, "R9 ack after write cycle", tries, 5);
    rd_seq(8'h05, 1, 1'b1);
    chk(all_ack && rbuf[0] == exp_m[5], "R3 R6 random read", rbuf[0], exp_m[5]);
  endtask

  task automatic t_page_write();
    int tries;
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h50 + 8'(k);
    wr_seq(8'h1D, 4);
    exp_m[8'h1D] = 8'h50;  exp_m[8'h1E] = 8'h51;
    exp_m[8'h1F] = 8'h52;  exp_m[8'h10] = 8'h53;
    poll(tries);
    rd_seq(8'h1D, 4, 1'b1);
    for (int k = 0; k < 3; k++)
      chk(rbuf[k] == exp_m[8'h1D + k], "R4 page bytes", rbuf[k], exp_m[8'h1D + k]);
    chk(rbuf[3] == exp_m[8'h20], "R4 next page untouched", rbuf[3], exp_m[8'h20]);
    rd_seq(8'h10, 1, 1'b1);
    chk(rbuf[0] == 8'h53, "R4 page rollover", rbuf[0], 8'h53);
  endtask

  task automatic t_seq_wrap();
    rd_seq(8'h7E, 3, 1'b1);
    chk(rbuf[0] == exp_m[8'h7E], "R7 seq byte0", rbuf[0], exp_m[8'h7E]);
    chk(rbuf[1] == exp_m[8'h7F], "R7 seq byte1", rbuf[1], exp_m[8'h7F]);
    chk(rbuf[2] == exp_m[0], "R7 wrap to zero", rbuf[2], exp_m[0]);
    rd_seq(8'h00, 1, 1'b0);
    chk(rbuf[0] == exp_m[1], "R7 current address read", rbuf[0], exp_m[1]);
  endtask

  task automatic t_abort();
    logic ack;
    int tries;
    bus_start();  send_bits(DW, 4);   // cut off, START aborts (R1)
    bus_start();
    send_byte(DW, ack);  send_byte(8'h40, ack);
    chk(ack, "R1 command after abort", ack, 1);
    send_byte(8'h11, ack);
    send_bits(8'h22, 4);
    bus_stop();                       // late STOP: no commit (R5)
    poll(tries);
    chk(tries == 1, "R5 no write cycle", tries, 1);
    rd_seq(8'h40, 1, 1'b1);
    chk(rbuf[0] == exp_m[8'h40], "R5 data unchanged", rbuf[0], exp_m[8'h40]);
  endtask

  task automatic t_wp();
    logic a_dev, a_word, a_dat;
    int tries;
    wp = 1'b1;
    bus_start();
    send_byte(DW, a_dev);  send_byte(8'h30, a_word);  send_byte(8'h99, a_dat);
    bus_stop();
    wp = 1'b0;
    chk(a_dev && a_word, "R10 address bytes acked", {a_dev, a_word}, 3);
    chk(!a_dat, "R10 data nack", a_dat, 0);
    poll(tries);
    chk(tries == 1, "R10 no write cycle", tries, 1);
    rd_seq(8'h30, 1, 1'b1);
    chk(rbuf[0] == exp_m[8'h30], "R10 data unchanged", rbuf[0], exp_m[8'h30]);
  endtask

  task automatic t_nack_end();
    logic ack;
    logic [7:0] b;
    bus_start();  send_byte(DR, ack);
    recv_byte(b, 1'b1);
    chk(ack && b == exp_m[2], "R8 host ack continues", b, exp_m[2]);
    recv_byte(b, 1'b0);
    chk(b == exp_m[3], "R8 last byte", b, exp_m[3]);
    wt(H);
    chk(sda_bus === 1'b1, "R8 released after nack", sda_bus, 1);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) exp_m[i] = 8'(i) ^ 8'hA5;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_addr_match();
    t_byte_write();
    t_page_write();
    t_seq_wrap();     // leaves the pointer at 2 after the current read
    t_nack_end();
    t_abort();
    t_wp();
    chk(viol == 0, "R11 drive timing", viol, 0);
    chk(delay_seen > 20, "R11 drive changes seen", delay_seen, 21);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (done == 0) begin
      total++;  bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule